// File: doc/BRIEF.md
# I2C Slave Receiver with Status Codes

This block is the receiving side of an I2C target that reports every bus event through an eight-bit status code and an interrupt flag. It watches SCL and SDA for a START. It shifts in the seven-bit address and the direction bit, most significant bit first, and checks them against a programmable own address and against the general-call address 0x00. It acknowledges a write to either address only while the acknowledge-enable input is high.

Once the block is addressed, it takes in data bytes. Each byte is acknowledged or refused according to the acknowledge-enable input, and its value is exposed on a data output. After every byte-level event the block raises its interrupt flag and holds SCL low until software clears the flag. The block also receives a pulse from the local bus master when that master loses arbitration. An address that arrives right after such a pulse produces a distinct code, so software can tell that its own transfer was abandoned.

A STOP, or a repeated START, that arrives while the block is addressed ends the transfer with its own code. With no event pending, the status output reads 0xF8.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, and whenever the interrupt flag is clear, status reads 0xF8. After reset the interrupt flag, the SCL hold and the SDA pull-down are all low.
- R2: An address byte whose upper seven bits equal the own address and whose bit 0 is 0 (write) is acknowledged when acknowledge-enable is 1. The acknowledge is SDA pulled low during the ninth clock. At the falling edge of that clock the interrupt rises with status 0x60.
- R3: The address byte 0x00 (general call) is acknowledged when acknowledge-enable is 1, and it posts status 0x70.
- R4: If the arbitration-lost pulse arrived since the last address evaluation or STOP, an acknowledged own address posts 0x68 instead of 0x60, and a general call posts 0x78 instead of 0x70. The evaluation consumes the pulse, so the next address posts a plain code.
- R5: The block does not acknowledge, posts no event, and stays unaddressed in three cases: acknowledge-enable is 0, the address matches neither own nor 0x00, or the own address carries bit 0 = 1 (read). Later bytes up to the next START are then ignored.
- R6: After own-address addressing, a data byte received with acknowledge-enable 1 is acknowledged and posts 0x80, and the byte appears on the data output.
- R7: After own-address addressing, a data byte received with acknowledge-enable 0 is not acknowledged and posts 0x88. The block then becomes unaddressed, and later bytes get no acknowledge and no event.
- R8: After general-call addressing, data bytes post 0x90 when acknowledged and 0x98 when refused, with the byte on the data output. After 0x98 the block becomes unaddressed.
- R9: A STOP or a repeated START while addressed posts 0xA0 without holding SCL. After a repeated START the block evaluates the following address normally.
- R10: After an address or data event, SCL is held low for as long as the interrupt flag is set. Pulsing the clear input drops the flag and the hold, and status returns to 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_hold_o | output | 1 | Pull SCL low (clock hold) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| own_addr_i | input | 7 | Programmed own address |
| aa_i | input | 1 | Acknowledge enable |
| arb_lost_i | input | 1 | Pulse: local master lost arbitration |
| si_clr_i | input | 1 | Pulse: clear interrupt flag |
| si_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| rx_data_o | output | 8 | Last received data byte |

## Verification
The assertions take several things about the inputs for granted. SDA changes only while SCL is low, except during START and STOP. Every bus level lasts longer than the two-stage input synchronizer. The clear pulse never lands in the same cycle as a new event, and acknowledge-enable is stable when the eighth SCL falling edge is seen. The bench master meets all of this: it holds each bus level for ten clocks, waits two clocks after each SCL fall before moving SDA, and changes acknowledge-enable or pulses clear only while SCL is parked low between bytes.

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_hold_o,
  output logic       sda_low_o,
  input  logic [6:0] own_addr_i,
  input  logic       aa_i,
  input  logic       arb_lost_i,
  input  logic       si_clr_i,
  output logic       si_o,
  output logic [7:0] status_o,
  output logic [7:0] rx_data_o
);

  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_DATA} mode_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  mode_t mode;
  logic [3:0] bitcnt;
  logic in_ack, acked, gc, arb_flag, arb_hit;
  logic [7:0] shreg, code;

  wire scl = scl_sy[SYNC_STAGES-1];
  wire sda = sda_sy[SYNC_STAGES-1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c = scl & scl_q & ~sda_q & sda;
  wire own_match = (shreg[7:1] == own_addr_i) && !shreg[0];
  wire gc_match = (shreg == 8'h00);

  assign status_o = si_o ? code : IDLE_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      acked <= 1'b0;
      gc <= 1'b0;
      arb_flag <= 1'b0;
      arb_hit <= 1'b0;
      shreg <= '0;
      code <= IDLE_CODE;
      si_o <= 1'b0;
      scl_hold_o <= 1'b0;
      sda_low_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      if (arb_lost_i) arb_flag <= 1'b1;
      if (si_clr_i) begin
        si_o <= 1'b0;
        scl_hold_o <= 1'b0;
      end
      if (start_c) begin
        if (mode == M_DATA) begin
          si_o <= 1'b1;
          code <= 8'hA0;
        end
        mode <= M_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_low_o <= 1'b0;
      end else if (stop_c) begin
        if (mode == M_DATA) begin
          si_o <= 1'b1;
          code <= 8'hA0;
        end
        mode <= M_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_low_o <= 1'b0;
        arb_flag <= 1'b0;
      end else if (mode != M_IDLE) begin
        if (scl_rise && !in_ack && bitcnt < 4'd8) begin
          shreg <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            sda_low_o <= 1'b0;
            bitcnt <= '0;
            si_o <= 1'b1;
            scl_hold_o <= 1'b1;
            if (mode == M_ADDR) begin
              mode <= M_DATA;
              code <= gc ? (arb_hit ? 8'h78 : 8'h70) : (arb_hit ? 8'h68 : 8'h60);
            end else begin
              code <= gc ? (acked ? 8'h90 : 8'h98) : (acked ? 8'h80 : 8'h88);
              if (!acked) mode <= M_IDLE;
            end
          end else if (bitcnt == 4'd8) begin
            if (mode == M_ADDR) begin
              arb_hit <= arb_flag;
              arb_flag <= 1'b0;
              if (aa_i && (own_match || gc_match)) begin
                in_ack <= 1'b1;
                sda_low_o <= 1'b1;
                gc <= gc_match;
              end else begin
                mode <= M_IDLE;
                bitcnt <= '0;
              end
            end else begin
              in_ack <= 1'b1;
              sda_low_o <= aa_i;
              acked <= aa_i;
              rx_data_o <= shreg;
            end
          end
        end
      end
    end
  end

  a_r5_ack_needs_aa: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> $past(aa_i));

  a_r10_event_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) |-> status_o inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0});

  a_r10_hold_implies_si: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o |-> si_o);

  a_r7_nack_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (si_o && status_o == 8'h88) |-> !sda_low_o);

endmodule

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h3A;
  logic aa = 1'b1, arb_lost = 1'b0, si_clr = 1'b0;
  logic scl_hold, sda_low, si;
  logic [7:0] status, rx_data;
  logic scl_bus, sda_bus;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [16:0] qe[$];
  string qr[$];
  logic si_prev = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_hold;
  assign sda_bus = m_sda & ~sda_low;

  i2c_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_hold_o(scl_hold), .sda_low_o(sda_low), .own_addr_i(own_addr),
    .aa_i(aa), .arb_lost_i(arb_lost), .si_clr_i(si_clr), .si_o(si),
    .status_o(status), .rx_data_o(rx_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && si && !si_prev) begin
      if (qe.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL unexpected event: actual %0h expected none", status);
      end else begin
        logic [16:0] it;
        string r;
        it = qe.pop_front();
        r = qr.pop_front();
        chk({r, " status"}, {8'h0, status}, {8'h0, it[7:0]});
        if (it[16]) chk({r, " data"}, {8'h0, rx_data}, {8'h0, it[15:8]});
      end
    end
    si_prev = si;
  end

  task automatic hp();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic qw();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic expect_ev(input logic [7:0] code, input logic [7:0] d, input bit chkd, input string req);
    qe.push_back({chkd, d, code});
    qr.push_back(req);
  endtask

  task automatic handle(input bit ev, input bit byte_ev, input string req);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk({req, " queue drained"}, 16'(qe.size()), 16'd0);
    qe.delete();
    qr.delete();
    if (ev) begin
      chk({req, " si set"}, {15'd0, si}, 16'd1);
      chk({req, " R10 hold"}, {15'd0, scl_hold}, {15'd0, byte_ev});
      @(posedge clk); #1 si_clr = 1'b1;
      @(posedge clk); #1 si_clr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({req, " R10 status idle"}, {8'h0, status}, 16'h00F8);
      chk({req, " R10 hold released"}, {15'd0, scl_hold}, 16'd0);
    end else begin
      chk({req, " no event"}, {15'd0, si}, 16'd0);
    end
    #1;
  endtask

  task automatic start_c();
    m_sda = 1'b1; m_scl = 1'b1; hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; qw();
  endtask

  task automatic rstart_c(input bit ev, input string req);
    if (ev) expect_ev(8'hA0, 8'h00, 1'b0, req);
    m_sda = 1'b1; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; qw();
    handle(ev, 1'b0, req);
  endtask

  task automatic stop_c(input bit ev, input string req);
    if (ev) expect_ev(8'hA0, 8'h00, 1'b0, req);
    m_sda = 1'b0; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b1; hp();
    handle(ev, 1'b0, req);
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input bit ev,
                      input logic [7:0] code, input bit chkd, input bit arb, input string req);
    if (ev) expect_ev(code, b, chkd, req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp();
      m_scl = 1'b1;
      if (arb && i == 4) begin
        @(posedge clk); #1 arb_lost = 1'b1;
        @(posedge clk); #1 arb_lost = 1'b0;
      end
      hp();
      m_scl = 1'b0; qw();
    end
    m_sda = 1'b1; hp();
    m_scl = 1'b1;
    repeat (H/2) @(posedge clk);
    @(negedge clk);
    chk({req, " ack"}, {15'd0, ~sda_bus}, {15'd0, exp_ack});
    hp();
    m_scl = 1'b0; qw();
    handle(ev, 1'b1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 status", {8'h0, status}, 16'h00F8);
    chk("R1 si", {15'd0, si}, 16'd0);
    chk("R1 hold", {15'd0, scl_hold}, 16'd0);
    chk("R1 sda", {15'd0, sda_low}, 16'd0);

    start_c();
    send(8'h74, 1, 1, 8'h60, 0, 0, "R2 own write");
    send(8'hA5, 1, 1, 8'h80, 1, 0, "R6 data A5");
    send(8'h5C, 1, 1, 8'h80, 1, 0, "R6 data 5C");
    stop_c(1, "R9 stop");

    start_c();
    send(8'h00, 1, 1, 8'h70, 0, 0, "R3 general call");
    send(8'h11, 1, 1, 8'h90, 1, 0, "R8 gc data ack");
    aa = 1'b0;
    send(8'h22, 0, 1, 8'h98, 1, 0, "R8 gc data nack");
    aa = 1'b1;
    send(8'h33, 0, 0, 8'h00, 0, 0, "R8 dropped after 98");
    stop_c(0, "R8 stop unaddressed");

    start_c();
    send(8'h74, 1, 1, 8'h68, 0, 1, "R4 own after arb loss");
    aa = 1'b0;
    send(8'h77, 0, 1, 8'h88, 1, 0, "R7 own data nack");
    aa = 1'b1;
    send(8'h44, 0, 0, 8'h00, 0, 0, "R7 dropped after 88");
    stop_c(0, "R7 stop unaddressed");

    start_c();
    send(8'h00, 1, 1, 8'h78, 0, 1, "R4 gc after arb loss");
    rstart_c(1, "R9 repeated start");
    send(8'h74, 1, 1, 8'h60, 0, 0, "R4 flag consumed R9 resume");
    stop_c(1, "R9 stop after resume");

    aa = 1'b0;
    start_c();
    send(8'h74, 0, 0, 8'h00, 0, 0, "R5 aa low");
    send(8'h74, 0, 0, 8'h00, 0, 0, "R5 ignored byte");
    stop_c(0, "R5 stop");
    aa = 1'b1;
    start_c();
    send(8'h76, 0, 0, 8'h00, 0, 0, "R5 mismatch");
    stop_c(0, "R5 stop mismatch");
    start_c();
    send(8'h75, 0, 0, 8'h00, 0, 0, "R5 read bit");
    stop_c(0, "R5 stop read");

    @(negedge clk);
    chk("R1 final idle", {8'h0, status}, 16'h00F8);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule